// File: doc/BRIEF.md
# Serial-Programmed Imaging Front-End Configuration Slave

This block is the configuration port of a CCD analog front end. A controller writes 12-bit words over a three-wire link: an enable, a serial clock and a data line. Each word carries a 2-bit register select followed by a 10-bit payload. The payload lands in one of four registers: the amplifier gain code, the overflow-drain DAC code, the black-clamp reference level, or a set of control-pulse polarity selects.

Gain, DAC and clamp writes first go to shadow copies. The copies move to the outputs that drive the analog path only on a vertical-sync edge. This way an exposure or gain change never lands in the middle of a frame. A polarity bit chooses whether the rising or the falling vertical-sync edge is used. The polarity register does not wait for that edge: its outputs follow a write at once.

The serial lines and the vertical-sync input are asynchronous to the core clock. Each passes through a two-stage synchronizer before any edge is detected. The core clock must be at least about eight times the serial clock, which runs at no more than 5 MHz.

Top module: `afe_cfg_regs`

## Requirements
- R1: After an active-low reset, the gain, DAC and clamp outputs are zero and every polarity output is 0.
- R2: On each rising serial clock while enable is high, one bit is sampled. The first bit is the high select bit and the second is the low select bit, followed by payload bits 9 down to 0. The word acts when enable falls. Select 00 is gain, 01 is DAC, 10 is clamp and 11 is polarity.
- R3: A word is dropped if enable falls after any count of bits other than exactly 12, for example 11 or 13. It then changes no register.
- R4: A gain write stores the 10-bit payload as a 9-bit code. Any payload above 383 becomes 383.
- R5: A DAC write keeps payload bits 7..0; payload bits 9 and 8 are ignored.
- R6: A clamp write keeps payload bits 6..0; payload bits 9..7 are ignored.
- R7: A polarity write drives the outputs within a few core cycles, with no vertical-sync edge needed. Payload bit 0 drives the sample-pulse level, bit 1 the pixel-clock edge, bit 2 the dummy-clamp level, bit 3 the black-clamp level, bit 5 the blanking level and bit 6 the vertical-sync edge select. Bit 4 has no effect.
- R8: The gain, DAC and clamp outputs change only when a selected vertical-sync edge occurs. A write alone leaves them unchanged.
- R9: When polarity bit 6 is 0, only the rising vertical-sync edge commits the shadow copies. When it is 1, only the falling edge does.
- R10: If a word takes effect in the same core cycle as a commit, the output takes the new value from that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_en_i | input | 1 | Serial word enable, high during a word |
| ser_clk_i | input | 1 | Serial bit clock, sampled on its rising edge |
| ser_dat_i | input | 1 | Serial data, most significant bit first |
| vsync_i | input | 1 | Vertical sync, asynchronous |
| gain_o | output | 9 | Active amplifier gain code, 0..383 |
| dac_o | output | 8 | Active overflow-drain DAC code |
| clamp_o | output | 7 | Active black-clamp reference level |
| pol_sample_o | output | 1 | Sample-pulse active level select |
| pol_pclk_o | output | 1 | Pixel-clock active edge select |
| pol_dummy_o | output | 1 | Dummy-clamp active level select |
| pol_ob_o | output | 1 | Optical-black clamp active level select |
| pol_blank_o | output | 1 | Blanking active level select |
| pol_vsync_o | output | 1 | Vertical-sync commit edge select (1 = falling) |

## Verification
A shadow write from a completed word and a frame commit from a vertical-sync edge can land on the same core edge. A careless design would then move the old shadow value to the output and lose the new word until the next frame. The bench provokes this by timing the two paths: it drops the serial enable one core cycle before it drops vertical sync. Falling-edge commit is selected at that point, so the extra register stage on the word path lines both events up. The DAC output is judged right after that edge: it must already show the new code, not the value from the previous frame.

// File: rtl/afe_cfg_pkg.sv
// Package: shared constants and types for the front-end configuration slave.
// Assumes a fixed 2-bit select plus 10-bit payload serial word.
package afe_cfg_pkg;
    localparam int SEL_W    = 2;
    localparam int PAY_W    = 10;
    localparam int FRAME_W  = SEL_W + PAY_W;
    localparam int GAIN_W   = 9;
    localparam int GAIN_MAX = 383;
    localparam int DAC_W    = 8;
    localparam int CLAMP_W  = 7;
    localparam int SYNC_STG = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_GAIN  = 2'b00,
        SEL_DAC   = 2'b01,
        SEL_CLAMP = 2'b10,
        SEL_POL   = 2'b11
    } reg_sel_e;

    typedef struct packed {
        logic vs_fall;   // payload bit 6
        logic blank;     // payload bit 5
        logic ob;        // payload bit 3
        logic dummy;     // payload bit 2
        logic pclk;      // payload bit 1
        logic sample;    // payload bit 0
    } pol_t;
endpackage

// File: rtl/afe_sync.sv
// Multi-stage synchronizer for a bus of independent asynchronous bits.
// Assumes each bit is sampled on its own; no bus coherency is claimed.
module afe_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] stg;

    // Shift the asynchronous inputs through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) stg <= '0;
        else        stg <= {stg[STAGES-2:0], d};
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/afe_ser_rx.sv
// Serial word receiver. Counts rising serial-clock edges while enable is high,
// shifts in bits MSB first and emits a one-cycle strobe on the falling enable
// if exactly FRAME_W bits arrived. Inputs must already be synchronized.
module afe_ser_rx
    import afe_cfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             s_en,
    input  logic             s_clk,
    input  logic             s_dat,
    output logic             wr_stb,
    output logic [SEL_W-1:0] wr_sel,
    output logic [PAY_W-1:0] wr_pay
);
    localparam int CNT_CAP = FRAME_W + 1;
    localparam int CNT_W   = $clog2(FRAME_W + 2);

    logic               en_q, sck_q;
    logic               sck_rise, en_fall;
    logic [FRAME_W-1:0] shreg;
    logic [CNT_W-1:0]   cnt;

    assign sck_rise = s_clk & ~sck_q;
    assign en_fall  = ~s_en & en_q;

    // Track line history, shift bits and count them with a saturating counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            sck_q <= 1'b0;
            shreg <= '0;
            cnt   <= '0;
        end else begin
            en_q  <= s_en;
            sck_q <= s_clk;
            if (!s_en) begin
                cnt <= '0;
            end else if (sck_rise) begin
                shreg <= {shreg[FRAME_W-2:0], s_dat};
                if (cnt != CNT_W'(CNT_CAP)) cnt <= cnt + 1'b1;
            end
        end
    end

    // Release a complete word when enable falls after exactly FRAME_W bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_stb <= 1'b0;
            wr_sel <= '0;
            wr_pay <= '0;
        end else begin
            wr_stb <= en_fall && (cnt == CNT_W'(FRAME_W));
            if (en_fall) begin
                wr_sel <= shreg[FRAME_W-1 -: SEL_W];
                wr_pay <= shreg[PAY_W-1:0];
            end
        end
    end
endmodule

// File: rtl/afe_reg_bank.sv
// Configuration register bank. Gain, DAC and clamp have a shadow copy and an
// active copy; the active copy loads on the selected frame edge, taking a
// same-cycle write into account. Polarity loads directly on its write.
module afe_reg_bank
    import afe_cfg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_stb,
    input  logic [SEL_W-1:0]   wr_sel,
    input  logic [PAY_W-1:0]   wr_pay,
    input  logic               fs_rise,
    input  logic               fs_fall,
    output logic               commit,
    output logic [GAIN_W-1:0]  gain_q,
    output logic [DAC_W-1:0]   dac_q,
    output logic [CLAMP_W-1:0] clamp_q,
    output pol_t               pol_q
);
    logic [GAIN_W-1:0]  gain_sh, gain_nx, gain_in;
    logic [DAC_W-1:0]   dac_sh, dac_nx;
    logic [CLAMP_W-1:0] clamp_sh, clamp_nx;
    logic               hit_gain, hit_dac, hit_clamp, hit_pol;

    assign hit_gain  = wr_stb && (wr_sel == SEL_GAIN);
    assign hit_dac   = wr_stb && (wr_sel == SEL_DAC);
    assign hit_clamp = wr_stb && (wr_sel == SEL_CLAMP);
    assign hit_pol   = wr_stb && (wr_sel == SEL_POL);

    // Saturate the incoming gain payload to the top legal code.
    always_comb begin
        if (wr_pay > PAY_W'(GAIN_MAX)) gain_in = GAIN_W'(GAIN_MAX);
        else                           gain_in = wr_pay[GAIN_W-1:0];
    end

    // Next shadow values, seen by a commit in the same cycle.
    always_comb begin
        gain_nx  = hit_gain  ? gain_in                : gain_sh;
        dac_nx   = hit_dac   ? wr_pay[DAC_W-1:0]      : dac_sh;
        clamp_nx = hit_clamp ? wr_pay[CLAMP_W-1:0]    : clamp_sh;
    end

    // Select the frame edge named by the polarity register.
    assign commit = pol_q.vs_fall ? fs_fall : fs_rise;

    // Shadow copies follow writes; active copies load on a commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gain_sh  <= '0;
            dac_sh   <= '0;
            clamp_sh <= '0;
            gain_q   <= '0;
            dac_q    <= '0;
            clamp_q  <= '0;
        end else begin
            gain_sh  <= gain_nx;
            dac_sh   <= dac_nx;
            clamp_sh <= clamp_nx;
            if (commit) begin
                gain_q  <= gain_nx;
                dac_q   <= dac_nx;
                clamp_q <= clamp_nx;
            end
        end
    end

    // Polarity selects bypass the frame latch; payload bit 4 is dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol_q <= '0;
        end else if (hit_pol) begin
            pol_q <= '{vs_fall: wr_pay[6], blank: wr_pay[5], ob: wr_pay[3],
                       dummy: wr_pay[2], pclk: wr_pay[1], sample: wr_pay[0]};
        end
    end
endmodule

// File: rtl/afe_cfg_regs.sv
// Top of the front-end configuration slave. Synchronizes the serial lines and
// vertical sync into the core clock, finds the frame edges, receives words and
// holds the configuration registers. Core clock must oversample the serial
// clock by about eight or more.
module afe_cfg_regs
    import afe_cfg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ser_en_i,
    input  logic               ser_clk_i,
    input  logic               ser_dat_i,
    input  logic               vsync_i,
    output logic [GAIN_W-1:0]  gain_o,
    output logic [DAC_W-1:0]   dac_o,
    output logic [CLAMP_W-1:0] clamp_o,
    output logic               pol_sample_o,
    output logic               pol_pclk_o,
    output logic               pol_dummy_o,
    output logic               pol_ob_o,
    output logic               pol_blank_o,
    output logic               pol_vsync_o
);
    logic [3:0]       sync_q;
    logic             s_vs, s_en, s_clk, s_dat;
    logic             vs_q, fs_rise, fs_fall;
    logic             wr_stb, commit;
    logic [SEL_W-1:0] wr_sel;
    logic [PAY_W-1:0] wr_pay;
    pol_t             pol_q;

    afe_sync #(.WIDTH(4), .STAGES(SYNC_STG)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({vsync_i, ser_en_i, ser_clk_i, ser_dat_i}),
        .q     (sync_q)
    );

    assign {s_vs, s_en, s_clk, s_dat} = sync_q;

    // Keep the previous synchronized sync level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) vs_q <= 1'b0;
        else        vs_q <= s_vs;
    end

    assign fs_rise = s_vs & ~vs_q;
    assign fs_fall = ~s_vs & vs_q;

    afe_ser_rx u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .s_en   (s_en),
        .s_clk  (s_clk),
        .s_dat  (s_dat),
        .wr_stb (wr_stb),
        .wr_sel (wr_sel),
        .wr_pay (wr_pay)
    );

    afe_reg_bank u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_stb  (wr_stb),
        .wr_sel  (wr_sel),
        .wr_pay  (wr_pay),
        .fs_rise (fs_rise),
        .fs_fall (fs_fall),
        .commit  (commit),
        .gain_q  (gain_o),
        .dac_q   (dac_o),
        .clamp_q (clamp_o),
        .pol_q   (pol_q)
    );

    assign pol_sample_o = pol_q.sample;
    assign pol_pclk_o   = pol_q.pclk;
    assign pol_dummy_o  = pol_q.dummy;
    assign pol_ob_o     = pol_q.ob;
    assign pol_blank_o  = pol_q.blank;
    assign pol_vsync_o  = pol_q.vs_fall;
endmodule

// File: rtl/afe_cfg_regs_chk.sv
// Checker for the configuration slave, bound onto the top. Relates the word
// strobe and frame commit to the register outputs over time.
module afe_cfg_regs_chk
    import afe_cfg_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               wr_stb,
    input logic [SEL_W-1:0]   wr_sel,
    input logic [PAY_W-1:0]   wr_pay,
    input logic               commit,
    input logic [GAIN_W-1:0]  gain_o,
    input logic [DAC_W-1:0]   dac_o,
    input logic [CLAMP_W-1:0] clamp_o,
    input logic [5:0]         pol_v
);
    assert_gain_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        gain_o <= GAIN_W'(GAIN_MAX));

    assert_hold_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable({gain_o, dac_o, clamp_o}));

    assert_pol_only_on_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_stb && wr_sel == SEL_POL) |=> $stable(pol_v));

    assert_strobe_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

    assert_coincident_dac_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && wr_stb && wr_sel == SEL_DAC) |=> dac_o == $past(wr_pay[DAC_W-1:0]));
endmodule

bind afe_cfg_regs afe_cfg_regs_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_stb  (wr_stb),
    .wr_sel  (wr_sel),
    .wr_pay  (wr_pay),
    .commit  (commit),
    .gain_o  (gain_o),
    .dac_o   (dac_o),
    .clamp_o (clamp_o),
    .pol_v   ({pol_vsync_o, pol_blank_o, pol_ob_o, pol_dummy_o, pol_pclk_o, pol_sample_o})
);

// File: tb/afe_cfg_regs_bench.sv
// Directed bench for the configuration slave: one task per scenario.
module afe_cfg_regs_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_en = 1'b0, ser_clk = 1'b0, ser_dat = 1'b0, vsync = 1'b0;
    logic [8:0] gain;
    logic [7:0] dac;
    logic [6:0] clamp;
    logic       p_sample, p_pclk, p_dummy, p_ob, p_blank, p_vs;
    int         n_chk = 0, n_err = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    afe_cfg_regs u_afe_cfg_regs (
        .clk(clk), .rst_n(rst_n), .ser_en_i(ser_en), .ser_clk_i(ser_clk),
        .ser_dat_i(ser_dat), .vsync_i(vsync), .gain_o(gain), .dac_o(dac),
        .clamp_o(clamp), .pol_sample_o(p_sample), .pol_pclk_o(p_pclk),
        .pol_dummy_o(p_dummy), .pol_ob_o(p_ob), .pol_blank_o(p_blank),
        .pol_vsync_o(p_vs)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Send n bits of the word {sel, pay}; bits past 12 are zero.
    task automatic send(input logic [1:0] sel, input logic [9:0] pay, input int n, input bit vs_drop);
        logic [11:0] w;
        w = {sel, pay};
        @(negedge clk); ser_en = 1'b1;
        repeat (4) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            ser_dat = (i < 12) ? w[11-i] : 1'b0;
            repeat (5) @(negedge clk);
            ser_clk = 1'b1;
            repeat (5) @(negedge clk);
            ser_clk = 1'b0;
        end
        repeat (3) @(negedge clk);
        ser_en = 1'b0;
        if (vs_drop) begin
            @(negedge clk);
            vsync = 1'b0;
        end
        repeat (8) @(negedge clk);
    endtask

    task automatic vs_set(input logic v);
        @(negedge clk); vsync = v;
        repeat (8) @(negedge clk);
    endtask

    task automatic t_reset;
        check("R1", "gain", gain, 0);
        check("R1", "dac", dac, 0);
        check("R1", "clamp", clamp, 0);
        check("R1", "pol", {p_vs, p_blank, p_ob, p_dummy, p_pclk, p_sample}, 0);
    endtask

    task automatic t_gain_frame;
        send(2'b00, 10'd200, 12, 1'b0);
        check("R8", "gain before frame edge", gain, 0);
        vs_set(1'b1);
        check("R2", "gain after rising edge", gain, 200);
        vs_set(1'b0);
        check("R9", "gain after falling edge (rising selected)", gain, 200);
    endtask

    task automatic t_gain_sat;
        send(2'b00, 10'h3FF, 12, 1'b0);
        vs_set(1'b1); vs_set(1'b0);
        check("R4", "saturated gain", gain, 383);
    endtask

    task automatic t_dac_clamp;
        send(2'b01, 10'h3A5, 12, 1'b0);
        send(2'b10, 10'h3D5, 12, 1'b0);
        check("R8", "dac before frame edge", dac, 0);
        vs_set(1'b1); vs_set(1'b0);
        check("R5", "dac upper bits dropped", dac, 8'hA5);
        check("R6", "clamp upper bits dropped", clamp, 7'h55);
    endtask

    task automatic t_pol;
        send(2'b11, 10'h010, 12, 1'b0);
        check("R7", "pol bit4 only", {p_vs, p_blank, p_ob, p_dummy, p_pclk, p_sample}, 0);
        send(2'b11, 10'h02B, 12, 1'b0);
        check("R7", "pol map immediate", {p_vs, p_blank, p_ob, p_dummy, p_pclk, p_sample}, 6'b011011);
    endtask

    task automatic t_bad_count;
        send(2'b00, 10'd50, 11, 1'b0);
        send(2'b00, 10'd50, 13, 1'b0);
        vs_set(1'b1); vs_set(1'b0);
        check("R3", "gain after short and long words", gain, 383);
    endtask

    task automatic t_edge_select;
        send(2'b11, 10'h040, 12, 1'b0);
        check("R7", "vsync edge select", p_vs, 1);
        send(2'b01, 10'h011, 12, 1'b0);
        vs_set(1'b1);
        check("R9", "dac after rising edge (falling selected)", dac, 8'hA5);
        vs_set(1'b0);
        check("R9", "dac after falling edge", dac, 8'h11);
    endtask

    task automatic t_same_cycle;
        vs_set(1'b1);
        send(2'b01, 10'h077, 12, 1'b1);
        check("R10", "dac with coincident word and commit", dac, 8'h77);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_gain_frame();
        t_gain_sat();
        t_dac_clamp();
        t_pol();
        t_bad_count();
        t_edge_select();
        t_same_cycle();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule